// File: doc/BRIEF.md
# Iterative AES Block Cipher Core

The core turns one 128-bit block into another with the AES cipher. It performs one full round per clock cycle, so a block finishes in 10 cycles with a 128-bit key and in 14 cycles with a 256-bit key. The key is kept in an internal 256-bit register, built as eight 32-bit words. Encryption and key derivation load this register from the key port. Decryption leaves the register alone and reuses it, so a stream of blocks under one key does not have to present the key again.

Round keys are not stored in a table. A rolling window of round-key words sits next to the state register and is moved one round key forward or backward in each cycle. Key derivation runs the whole forward schedule and writes the final window back into the key register. That final window is the last round key for a 128-bit key, and the last two round keys for a 256-bit key. Decryption then walks the schedule backward from it. Byte substitution is computed as an inversion in GF(2^8) followed by an affine map, so the core needs no lookup contents.

The operation is picked by a 2-bit code sampled together with a start pulse. A one-cycle done pulse marks the moment the result register has been updated.

Top module: `aes_iter_core`

## Requirements
- R1: While reset is asserted and after reset is released, data_o reads all zeros and done_o is low until the first operation completes.
- R2: Mode code 2'b00 with key_size_i = 0 encrypts data_i under the 128-bit key held in key_i[255:128] with 10 AES rounds. data_i[127:120] is the first byte of the block, and data_o uses the same byte order.
- R3: Mode code 2'b00 with key_size_i = 1 encrypts data_i under the 256-bit key key_i[255:0] with 14 AES rounds. The first key byte is key_i[255:248].
- R4: When a start is accepted at clock edge N, done_o is high for exactly one cycle after edge N+Nr, where Nr is 10 or 14. data_o holds the new result in that same cycle.
- R5: Mode code 2'b10 (derive) loads the key register from key_i and key_size_i and runs the full forward key schedule. It then replaces the key register with the final schedule window and pulses done_o. data_o keeps its previous value.
- R6: Mode code 2'b01 (decrypt) starts from the derived key in the key register. It runs the schedule backward and returns the plaintext of data_i, for both key sizes.
- R7: Decryption reads neither key_i nor key_size_i and does not change the key register. Several blocks can be decrypted in a row after a single derive.
- R8: A start while an operation is running is ignored. The running operation finishes with its own result and timing, and no second done pulse follows.
- R9: A start with the reserved mode code 2'b11 is ignored. No done pulse follows and data_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| start_i | input | 1 | Start request, sampled while the core is idle |
| mode_i | input | 2 | 00 encrypt, 01 decrypt, 10 derive, 11 reserved |
| key_size_i | input | 1 | 0 for a 128-bit key, 1 for a 256-bit key (used by encrypt and derive) |
| key_i | input | 256 | Key; a 128-bit key occupies the upper half |
| data_i | input | 128 | Input block, first byte in the top bits |
| data_o | output | 128 | Result block |
| done_o | output | 1 | One-cycle pulse when an operation completes |

## Verification
The embedded assertions check these properties on every cycle:
- done is always a single-cycle pulse.
- The round counter stays inside 1..Nr and steps by exactly one while an operation runs, even when start is raised.
- A reserved or busy start never launches an operation.
- Decryption never touches the key register.
- A derive never alters the result register.

Some properties can only be shown by the bench scenarios, which compare results against published AES vectors:
- The cipher output is correct for both key sizes.
- A derived key really inverts the matching encryption.
- The stored key survives several decryptions while the key port carries garbage.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;

  localparam int BLK_W       = 128;
  localparam int KEY_W       = 256;
  localparam int WORD_W      = 32;
  localparam int NR_SHORT    = 10;
  localparam int NR_LONG     = 14;
  localparam int CNT_W       = $clog2(NR_LONG + 2);
  localparam int SYNC_STAGES = 2;
  localparam int COLS        = BLK_W / WORD_W;

  typedef enum logic [1:0] {
    OP_ENC = 2'b00,
    OP_DEC = 2'b01,
    OP_DRV = 2'b10,
    OP_RSV = 2'b11
  } aes_op_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // x^254 gives the multiplicative inverse; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] x2, x3, x6, x12, x15, x30, x60, x120, x240, x252;
    x2   = gf_mul(x, x);
    x3   = gf_mul(x2, x);
    x6   = gf_mul(x3, x3);
    x12  = gf_mul(x6, x6);
    x15  = gf_mul(x12, x3);
    x30  = gf_mul(x15, x15);
    x60  = gf_mul(x30, x30);
    x120 = gf_mul(x60, x60);
    x240 = gf_mul(x120, x120);
    x252 = gf_mul(x240, x12);
    return gf_mul(x252, x2);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return 8'((x << n) | (x >> (8 - n)));
  endfunction

  function automatic logic [7:0] aff_fwd(input logic [7:0] x);
    return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] aff_inv(input logic [7:0] y);
    return rotl8(y, 1) ^ rotl8(y, 3) ^ rotl8(y, 6) ^ 8'h05;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    return aff_fwd(gf_inv(x));
  endfunction

  function automatic logic [7:0] rcon(input logic [CNT_W-1:0] idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < (1 << CNT_W); i++) begin
      if (i < int'(idx)) r = xtime(r);
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] sub_word(input logic [WORD_W-1:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
    return {w[23:0], w[31:24]};
  endfunction

  function automatic logic [WORD_W-1:0] mix_col(input logic [WORD_W-1:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic logic [WORD_W-1:0] inv_mix_col(input logic [WORD_W-1:0] w);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = w;
    return {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
            gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
            gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
            gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
  endfunction

endpackage

// File: rtl/aes_iter_rstsync.sv
module aes_iter_rstsync
  import aes_iter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_ns = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/aes_iter_round.sv
module aes_iter_round
  import aes_iter_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             dec_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);

  logic [BLK_W-1:0] subbed;

  // byte k of the block sits at bits [BLK_W-1-8k -: 8]; row = k%4, column = k/4
  for (genvar k = 0; k < 16; k++) begin : g_byte
    localparam int ROW   = k % 4;
    localparam int COL   = k / 4;
    localparam int SRC_E = ROW + 4 * ((COL + ROW) % 4);
    localparam int SRC_D = ROW + 4 * ((COL - ROW + 4) % 4);
    logic [7:0] pick;
    logic [7:0] inv;
    always_comb begin
      pick = dec_i ? state_i[BLK_W-1-8*SRC_D -: 8] : state_i[BLK_W-1-8*SRC_E -: 8];
      inv  = gf_inv(dec_i ? aff_inv(pick) : pick);
      subbed[BLK_W-1-8*k -: 8] = dec_i ? inv : aff_fwd(inv);
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [WORD_W-1:0] col;
    logic [WORD_W-1:0] rk;
    logic [WORD_W-1:0] keyed;
    always_comb begin
      col   = subbed[BLK_W-1-WORD_W*c -: WORD_W];
      rk    = rkey_i[BLK_W-1-WORD_W*c -: WORD_W];
      keyed = col ^ rk;
      if (dec_i) begin
        state_o[BLK_W-1-WORD_W*c -: WORD_W] = last_i ? keyed : inv_mix_col(keyed);
      end else begin
        state_o[BLK_W-1-WORD_W*c -: WORD_W] = (last_i ? col : mix_col(col)) ^ rk;
      end
    end
  end

endmodule

// File: rtl/aes_iter_keyexp.sv
module aes_iter_keyexp
  import aes_iter_pkg::*;
(
  input  logic [KEY_W-1:0] win_i,
  input  logic             bwd_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] gidx_i,
  output logic [KEY_W-1:0] win_o,
  output logic [BLK_W-1:0] rkey_o
);

  logic [0:3][WORD_W-1:0] hi_w, lo_w, nxt_w, prv_w, src_w;
  logic [WORD_W-1:0]      f_in, f_out;
  logic                   use_rot;
  logic [CNT_W-1:0]       rc_idx;

  always_comb begin
    hi_w  = win_i[KEY_W-1 -: BLK_W];
    lo_w  = win_i[BLK_W-1:0];
    src_w = wide_i ? lo_w : hi_w;

    // undo the chained xors of the newest round key
    prv_w[0] = '0;
    for (int i = 1; i < 4; i++) prv_w[i] = src_w[i] ^ src_w[i-1];

    // one shared word transform for all four directions/sizes
    case ({bwd_i, wide_i})
      2'b00:   f_in = hi_w[3];
      2'b01:   f_in = lo_w[3];
      2'b10:   f_in = prv_w[3];
      default: f_in = hi_w[3];
    endcase
    use_rot = !wide_i || !gidx_i[0];
    rc_idx  = wide_i ? (gidx_i >> 1) : gidx_i;
    f_out   = sub_word(use_rot ? rot_word(f_in) : f_in) ^
              (use_rot ? {rcon(rc_idx), 24'h000000} : '0);

    nxt_w[0] = hi_w[0] ^ f_out;
    for (int i = 1; i < 4; i++) nxt_w[i] = hi_w[i] ^ nxt_w[i-1];
    prv_w[0] = src_w[0] ^ f_out;

    case ({bwd_i, wide_i})
      2'b00:   begin win_o = {nxt_w, lo_w}; rkey_o = nxt_w; end
      2'b01:   begin win_o = {lo_w, nxt_w}; rkey_o = lo_w;  end
      2'b10:   begin win_o = {prv_w, lo_w}; rkey_o = prv_w; end
      default: begin win_o = {prv_w, hi_w}; rkey_o = hi_w;  end
    endcase
  end

endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_iter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic             key_size_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [BLK_W-1:0] data_i,
  output logic [BLK_W-1:0] data_o,
  output logic             done_o
);

  logic             rst_ns;
  logic [BLK_W-1:0] state_q, state_d, round_out, rk_round, rk_first;
  logic [KEY_W-1:0] win_q, win_d, win_step, key_q, key_d, key_src;
  logic [BLK_W-1:0] res_q, res_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, nr, gidx;
  aes_op_e          op_q, op_d, mode_op;
  logic             run_q, run_d, wide_q, wide_d, done_q, done_d;
  logic             go, last, bwd, state_en, key_en, res_en;

  aes_iter_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  assign mode_op = aes_op_e'(mode_i);
  assign go      = start_i && !run_q && (mode_op != OP_RSV);
  assign nr      = wide_q ? CNT_W'(NR_LONG) : CNT_W'(NR_SHORT);
  assign last    = (cnt_q == nr);
  assign bwd     = (op_q == OP_DEC);
  assign gidx    = bwd ? CNT_W'(nr - cnt_q + 1'b1)
                       : (wide_q ? CNT_W'(cnt_q + 1'b1) : cnt_q);

  aes_iter_keyexp u_key (
    .win_i (win_q),
    .bwd_i (bwd),
    .wide_i(wide_q),
    .gidx_i(gidx),
    .win_o (win_step),
    .rkey_o(rk_round)
  );

  aes_iter_round u_round (
    .state_i(state_q),
    .rkey_i (rk_round),
    .dec_i  (bwd),
    .last_i (last),
    .state_o(round_out)
  );

  // first round key: K0 for encrypt/derive, the final key for decrypt
  always_comb begin
    key_src  = (mode_op == OP_DEC) ? key_q : key_i;
    rk_first = key_src[KEY_W-1 -: BLK_W];
    if (mode_op == OP_DEC && wide_q) rk_first = key_q[BLK_W-1:0];
  end

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    key_d   = key_q;
    wide_d  = wide_q;
    res_d   = res_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    run_d   = run_q;
    done_d  = 1'b0;
    if (go) begin
      state_d = data_i ^ rk_first;
      win_d   = key_src;
      cnt_d   = CNT_W'(1);
      op_d    = mode_op;
      run_d   = 1'b1;
      if (mode_op != OP_DEC) begin
        key_d  = key_i;
        wide_d = key_size_i;
      end
    end else if (run_q) begin
      state_d = round_out;
      if (!(wide_q && last)) win_d = win_step;
      cnt_d = CNT_W'(cnt_q + 1'b1);
      if (last) begin
        run_d  = 1'b0;
        done_d = 1'b1;
        if (op_q == OP_DRV) key_d = win_d;
        else                res_d = round_out;
      end
    end
  end

  assign state_en = go || run_q;
  assign key_en   = (go && mode_op != OP_DEC) || (run_q && last && op_q == OP_DRV);
  assign res_en   = run_q && last && op_q != OP_DRV;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= '0;
      win_q   <= '0;
      key_q   <= '0;
      wide_q  <= 1'b0;
      res_q   <= '0;
      cnt_q   <= '0;
      op_q    <= OP_ENC;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (state_en) begin
        state_q <= state_d;
        win_q   <= win_d;
        cnt_q   <= cnt_d;
        op_q    <= op_d;
        run_q   <= run_d;
        wide_q  <= wide_d;
      end
      if (key_en) key_q <= key_d;
      if (res_en) res_q <= res_d;
      done_q <= done_d;
    end
  end

  assign data_o = res_q;
  assign done_o = done_q;

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done_o |=> !done_o);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    run_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= nr));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (run_q && !last && start_i) |=>
      (run_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1) && op_q == $past(op_q)));

  // R9
  rsv_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!run_q && start_i && mode_op == OP_RSV) |=> (!run_q && !done_o));

  // R7
  dec_key_kept_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (run_q && op_q == OP_DEC) |=> $stable(key_q));

  // R5
  drv_result_kept_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (run_q && op_q == OP_DRV) |=> $stable(data_o));

endmodule

// File: tb/test_aes_iter_core.sv
module test_aes_iter_core;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   mode_i;
  logic         key_size_i;
  logic [255:0] key_i;
  logic [127:0] data_i;
  logic [127:0] data_o;
  logic         done_o;

  always #5 clk = ~clk;

  aes_iter_core i_aes_iter_core (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .key_size_i(key_size_i), .key_i(key_i), .data_i(data_i),
    .data_o(data_o), .done_o(done_o)
  );

  typedef struct {
    logic [127:0] exp;
    int           cyc;
    string        tag;
  } item_t;

  item_t sbq[$];
  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int dones = 0;

  localparam logic [255:0] K1 = {128'h000102030405060708090a0b0c0d0e0f, 128'h0};
  localparam logic [255:0] K2 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
  localparam logic [255:0] K3 = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] C3 = 128'h8ea2b7ca516745bfeafc49904b496089;

  logic [127:0] last_res = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as done pulses appear
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      item_t it;
      dones++;
      if (sbq.size() == 0) begin
        check(1'b0, "R8/R9", "unexpected done", data_o, '0);
      end else begin
        it = sbq.pop_front();
        check(data_o === it.exp, it.tag, "result", data_o, it.exp);
        check(cyc == it.cyc, "R4", "done timing", 128'(cyc), 128'(it.cyc));
      end
    end
  end

  task automatic wait_empty();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: one operation, expected item pushed into the scoreboard
  task automatic run_op(input logic [1:0] md, input logic sz, input logic [255:0] k,
                        input logic [127:0] d, input logic [127:0] exp,
                        input int nr, input string tag);
    item_t it;
    @(negedge clk);
    start_i    = 1'b1;
    mode_i     = md;
    key_size_i = sz;
    key_i      = k;
    data_i     = d;
    it.exp = exp;
    it.cyc = cyc + 1 + nr;
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    start_i    = 1'b0;
    key_i      = {8{32'hdeadbeef}};
    key_size_i = ~sz;
    data_i     = '1;
    wait_empty();
    last_res = exp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d0;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 2'b00; key_size_i = 1'b0;
    key_i = '0; data_i = '0;
    repeat (3) @(negedge clk);
    check(data_o === '0, "R1", "data_o in reset", data_o, '0);
    check(done_o === 1'b0, "R1", "done_o in reset", 128'(done_o), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(data_o === '0 && done_o === 1'b0, "R1", "after release", data_o, '0);

    // R2: 128-bit encryption, two vectors
    run_op(2'b00, 1'b0, K1, P1, C1, 10, "R2");
    run_op(2'b00, 1'b0, K2, P2, C2, 10, "R2");
    // R3: 256-bit encryption
    run_op(2'b00, 1'b1, K3, P1, C3, 14, "R3");
    // R5: derive keeps data_o
    run_op(2'b10, 1'b0, K2, P1, last_res, 10, "R5");
    // R6, R7: decrypt twice from the derived key, key port garbage
    run_op(2'b01, 1'b1, {8{32'h5a5a5a5a}}, C2, P2, 10, "R6");
    run_op(2'b01, 1'b1, {8{32'ha5a5a5a5}}, C2, P2, 10, "R7");
    // R5/R6 with a 256-bit key
    run_op(2'b10, 1'b1, K3, P2, last_res, 14, "R5");
    run_op(2'b01, 1'b0, '0, C3, P1, 14, "R6");
    run_op(2'b10, 1'b0, K1, C1, last_res, 10, "R5");
    run_op(2'b01, 1'b1, '1, C1, P1, 10, "R7");

    // R8: start while busy must be ignored
    begin
      item_t it;
      @(negedge clk);
      start_i = 1'b1; mode_i = 2'b00; key_size_i = 1'b0; key_i = K1; data_i = P1;
      it.exp = C1; it.cyc = cyc + 11; it.tag = "R8";
      sbq.push_back(it);
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      start_i = 1'b1; mode_i = 2'b10; key_size_i = 1'b1; key_i = K3; data_i = P2;
      @(negedge clk);
      start_i = 1'b0;
      wait_empty();
      d0 = dones;
      repeat (20) @(negedge clk);
      check(dones == d0, "R8", "no second done", 128'(dones), 128'(d0));
      last_res = C1;
    end

    // R9: reserved mode code
    d0 = dones;
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'b11; key_size_i = 1'b0; key_i = K2; data_i = P2;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    check(dones == d0, "R9", "no done after reserved", 128'(dones), 128'(d0));
    check(data_o === last_res, "R9", "data_o unchanged", data_o, last_res);

    // R2: encryption reloads key after derive activity
    run_op(2'b00, 1'b0, K2, P2, C2, 10, "R2");

    check(sbq.size() == 0, "R4", "scoreboard drained", 128'(sbq.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule